// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This controller sits next to a small 8-bit processor core and decides when the core must leave its program flow to serve an interrupt. Peripherals and external pins send single-cycle event pulses. Each pulse sets a per-source pending flag, and it does so even while that source is masked. A flag becomes a request only when the source's own enable bit and a global enable bit are both set. Each source belongs to one of two priority levels.

At every instruction boundary the processor signals that an instruction has completed. If an allowed request exists at that moment, the controller raises a take strobe and drives the vector address of the winning source. The processor then performs the call. Two in-service bits, one per level, record which handlers are running. A high-level request may interrupt a running low-level handler. Nothing interrupts a high-level handler, and a low-level request waits while any handler runs. A return-from-interrupt strobe clears the higher in-service bit that is set. No request is taken on the boundary where the return completes, so a flag that software left set is served again only after one further instruction.

Software reads and writes the flags, enables, levels and global enable through a small register port. A parameter selects which sources have their flag cleared by hardware when their vector is taken.

Top module: `dual_level_irq_ctrl`

## Requirements
- R1: After reset all pending flags, source enables, level bits, the global enable and both in-service bits are 0, and req_o and take_o are 0.
- R2: An event pulse on evt_i[i] sets pending flag i on the next clock edge, whatever the enable settings are.
- R3: A register write to address 0 loads the pending flags from cfg_wdata_i. A bit written as 0 clears its flag even when an event for that source arrives in the same cycle. An event in a later cycle sets the flag again.
- R4: A source is eligible only when its pending flag, its enable bit (address 1) and the global enable (address 3, bit 7) are all 1. A pending flag without these produces no req_o and no take.
- R5: take_o is 1 exactly in a cycle where req_o is 1, instr_done_i is 1 and reti_i is 0.
- R6: Level bit i at address 2 set to 1 places source i at the high level. An allowed high-level request wins over any low-level request. Within a level, the lowest source index wins.
- R7: While req_o is 1, vec_o equals 3 + 8 × (winning source index). Otherwise vec_o is 0.
- R8: A take sets the in-service bit of the winner's level. A high-level request is allowed while only the low in-service bit is set. No request is allowed while the high in-service bit is set. A low-level request is not allowed while either in-service bit is set.
- R9: reti_i clears the high in-service bit if it is set, and otherwise clears the low in-service bit.
- R10: On a take, the winner's pending flag is cleared when the corresponding AUTOCLR parameter bit is 1. Otherwise the flag stays set.
- R11: No take occurs in the cycle reti_i is 1, which is the boundary where the return completes. A flag still set and allowed is taken at the next instruction boundary.
- R12: cfg_rdata_o returns the pending flags (address 0), enables (1) and level bits (2) in the low bits, and the global enable in bit 7 of address 3. All other bits read as 0.

Each address above is the value of cfg_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_SRC | Per-source event pulses |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data for cfg_addr_i |
| instr_done_i | input | 1 | An instruction completes this cycle |
| reti_i | input | 1 | The completing instruction is a return-from-interrupt |
| req_o | output | 1 | An allowed request is waiting |
| take_o | output | 1 | Vector to vec_o at this boundary |
| vec_o | output | VEC_W | Vector address of the winning source |

## Verification
The bench builds the block with six sources and an auto-clear mask that covers sources 0 and 2. With this mask, a single run exercises both hardware-cleared flags and flags that software must clear. Six sources are enough to hold several low-level sources pending at once behind a single high-level source. Directed sequences then reach high-over-low preemption, blocked same-level nesting, re-entry one instruction after a return, and a clear that collides with an event. A random phase then mixes events, writes and returns against a reference model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CFG_DW  = 8;
  localparam int GEN_BIT = 7;

  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_EN   = 2'd1,
    SEL_LVL  = 2'd2,
    SEL_CTL  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             sw_wr_i,
  input  logic [N_SRC-1:0] sw_wdata_i,
  input  logic [N_SRC-1:0] hw_clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] pend_d;
  logic [N_SRC-1:0] sw_clr;

  assign sw_clr = sw_wr_i ? ~sw_wdata_i : '0;

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    always_comb begin
      pend_d[i] = pend_q[i];
      if (sw_clr[i])                                pend_d[i] = 1'b0;
      else if (evt_i[i] || (sw_wr_i && sw_wdata_i[i])) pend_d[i] = 1'b1;
      else if (hw_clr_i[i])                         pend_d[i] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend_d[i];
    end
  end

  assign pend_o = pend_q;

  // R2
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |evt_i |=> ((pend_q & $past(evt_i & ~sw_clr)) == $past(evt_i & ~sw_clr)));

  // R3
  sw_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_i |=> ((pend_q & ~$past(sw_wdata_i)) == '0));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_SRC = 6,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign found_o = |req_i;
endmodule

// File: rtl/irq_insvc_track.sv
module irq_insvc_track (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  logic take_hi_i,
  input  logic reti_i,
  output logic ins_hi_o,
  output logic ins_lo_o
);
  logic ins_hi_q, ins_lo_q;
  logic ins_hi_d, ins_lo_d;

  always_comb begin
    ins_hi_d = ins_hi_q;
    ins_lo_d = ins_lo_q;
    if (take_i) begin
      if (take_hi_i) ins_hi_d = 1'b1;
      else           ins_lo_d = 1'b1;
    end else if (reti_i) begin
      if (ins_hi_q)  ins_hi_d = 1'b0;
      else           ins_lo_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_hi_q <= 1'b0;
      ins_lo_q <= 1'b0;
    end else begin
      ins_hi_q <= ins_hi_d;
      ins_lo_q <= ins_lo_d;
    end
  end

  assign ins_hi_o = ins_hi_q;
  assign ins_lo_o = ins_lo_q;

  // R8
  take_marks_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> ($past(take_hi_i) ? ins_hi_q : ins_lo_q));

  // R9
  reti_drops_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !take_i && ins_hi_q) |=> (!ins_hi_q && $stable(ins_lo_q)));
endmodule

// File: rtl/dual_level_irq_ctrl.sv
module dual_level_irq_ctrl
  import irq_pkg::*;
#(
  parameter int               N_SRC      = 6,
  parameter logic [N_SRC-1:0] AUTOCLR    = N_SRC'(5),
  parameter int               VEC_W      = 16,
  parameter int               VEC_BASE   = 3,
  parameter int               VEC_STRIDE = 8,
  localparam int              IDX_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  output logic [CFG_DW-1:0] cfg_rdata_o,
  input  logic              instr_done_i,
  input  logic              reti_i,
  output logic              req_o,
  output logic              take_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [N_SRC-1:0] en_q, en_d, lvl_q, lvl_d;
  logic             gen_q, gen_d;
  logic [N_SRC-1:0] pend, eligible, hi_req, lo_req, hw_clr;
  logic             hi_found, lo_found, hi_ok, lo_ok;
  logic [IDX_W-1:0] hi_idx, lo_idx, win_idx;
  logic             ins_hi, ins_lo;
  logic             pend_wr;
  logic             unused_wdata;

  assign unused_wdata = ^cfg_wdata_i;
  assign pend_wr      = cfg_we_i && (cfg_addr_i == SEL_PEND);

  // configuration registers: next state
  always_comb begin
    en_d  = en_q;
    lvl_d = lvl_q;
    gen_d = gen_q;
    if (cfg_we_i) begin
      case (cfg_addr_i)
        SEL_EN:  en_d  = cfg_wdata_i[N_SRC-1:0];
        SEL_LVL: lvl_d = cfg_wdata_i[N_SRC-1:0];
        SEL_CTL: gen_d = cfg_wdata_i[GEN_BIT];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      lvl_q <= '0;
      gen_q <= 1'b0;
    end else if (cfg_we_i) begin
      en_q  <= en_d;
      lvl_q <= lvl_d;
      gen_q <= gen_d;
    end
  end

  irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .sw_wr_i    (pend_wr),
    .sw_wdata_i (cfg_wdata_i[N_SRC-1:0]),
    .hw_clr_i   (hw_clr),
    .pend_o     (pend)
  );

  // masking and per-level arbitration
  assign eligible = pend & en_q & {N_SRC{gen_q}};
  assign hi_req   = eligible & lvl_q;
  assign lo_req   = eligible & ~lvl_q;

  irq_prio_pick #(.N_SRC(N_SRC)) u_pick_hi (
    .req_i (hi_req), .found_o (hi_found), .idx_o (hi_idx)
  );
  irq_prio_pick #(.N_SRC(N_SRC)) u_pick_lo (
    .req_i (lo_req), .found_o (lo_found), .idx_o (lo_idx)
  );

  assign hi_ok   = hi_found && !ins_hi;
  assign lo_ok   = lo_found && !ins_hi && !ins_lo;
  assign req_o   = hi_ok || lo_ok;
  assign win_idx = hi_ok ? hi_idx : lo_idx;
  assign take_o  = req_o && instr_done_i && !reti_i;
  assign vec_o   = req_o ? VEC_W'(VEC_BASE + VEC_STRIDE * int'(win_idx)) : '0;
  assign hw_clr  = take_o ? (AUTOCLR & (N_SRC'(1) << win_idx)) : '0;

  irq_insvc_track u_insvc (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (take_o),
    .take_hi_i (hi_ok),
    .reti_i    (reti_i),
    .ins_hi_o  (ins_hi),
    .ins_lo_o  (ins_lo)
  );

  // register read-back
  always_comb begin
    cfg_rdata_o = '0;
    case (cfg_addr_i)
      SEL_PEND: cfg_rdata_o[N_SRC-1:0] = pend;
      SEL_EN:   cfg_rdata_o[N_SRC-1:0] = en_q;
      SEL_LVL:  cfg_rdata_o[N_SRC-1:0] = lvl_q;
      default:  cfg_rdata_o[GEN_BIT]   = gen_q;
    endcase
  end

  // R4
  gen_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q |-> !req_o);

  // R8
  hi_not_preempted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_hi |-> !take_o);

  // R8
  lo_only_by_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_lo && take_o) |-> |(lvl_q & (N_SRC'(1) << win_idx)));

  // R11
  reti_then_retake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reti_i) && instr_done_i && !reti_i && req_o) |-> take_o);
endmodule

// File: tb/dual_level_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_level_irq_ctrl_tb_top;
  localparam int         N  = 6;
  localparam logic [5:0] AC = 6'b000101;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  b_evt;
  logic        b_we, b_done, b_reti;
  logic [1:0]  b_addr;
  logic [7:0]  b_wd;
  logic [7:0]  rdata;
  logic        req, take;
  logic [15:0] vec;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [5:0] m_pend, m_en, m_lvl;
  logic       m_gen, m_ih, m_il;
  logic       e_req, e_hi;
  int         e_idx;

  always #10 clk = ~clk;

  dual_level_irq_ctrl #(.N_SRC(N), .AUTOCLR(AC)) dut_i (
    .clk (clk), .rst_n (rst_n), .evt_i (b_evt),
    .cfg_we_i (b_we), .cfg_addr_i (b_addr), .cfg_wdata_i (b_wd),
    .cfg_rdata_o (rdata), .instr_done_i (b_done), .reti_i (b_reti),
    .req_o (req), .take_o (take), .vec_o (vec)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [5:0] v);
    for (int i = 5; i >= 0; i--) if (v[i]) lowest = i;
  endfunction

  task automatic model_eval();
    logic [5:0] el, hi, lo;
    el = m_pend & m_en & {6{m_gen}};
    hi = el & m_lvl;
    lo = el & ~m_lvl;
    e_req = 1'b0; e_hi = 1'b0; e_idx = 0;
    if (hi != 0 && !m_ih) begin
      e_req = 1'b1; e_hi = 1'b1; e_idx = lowest(hi);
    end else if (lo != 0 && !m_ih && !m_il) begin
      e_req = 1'b1; e_idx = lowest(lo);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0:    model_read = {2'b0, m_pend};
      2'd1:    model_read = {2'b0, m_en};
      2'd2:    model_read = {2'b0, m_lvl};
      default: model_read = {m_gen, 7'b0};
    endcase
  endfunction

  // drive at the falling edge, compare after settling
  task automatic drive(input logic [5:0] ev, input logic we, input logic [1:0] a,
                       input logic [7:0] wd, input logic dn, input logic rt);
    logic exp_take;
    b_evt = ev; b_we = we; b_addr = a; b_wd = wd; b_done = dn; b_reti = rt;
    #1;
    model_eval();
    exp_take = e_req && dn && !rt;
    chk("R4 req_o", int'(req), int'(e_req));
    chk("R5 take_o", int'(take), int'(exp_take));
    chk("R7 vec_o", int'(vec), e_req ? 3 + 8 * e_idx : 0);
    chk("R12 cfg_rdata_o", int'(rdata), int'(model_read(a)));
  endtask

  task automatic tick();
    logic       tk;
    logic [5:0] clr, ac;
    @(posedge clk);
    model_eval();
    tk  = e_req && b_done && !b_reti;
    clr = (b_we && b_addr == 2'd0) ? ~b_wd[5:0] : 6'b0;
    ac  = tk ? (AC & (6'b1 << e_idx)) : 6'b0;
    for (int i = 0; i < 6; i++) begin
      if (clr[i]) m_pend[i] = 1'b0;
      else if (b_evt[i] || (b_we && b_addr == 2'd0 && b_wd[i])) m_pend[i] = 1'b1;
      else if (ac[i]) m_pend[i] = 1'b0;
    end
    if (tk) begin
      if (e_hi) m_ih = 1'b1; else m_il = 1'b1;
    end else if (b_reti) begin
      if (m_ih) m_ih = 1'b0; else m_il = 1'b0;
    end
    if (b_we) begin
      if (b_addr == 2'd1) m_en  = b_wd[5:0];
      if (b_addr == 2'd2) m_lvl = b_wd[5:0];
      if (b_addr == 2'd3) m_gen = b_wd[7];
    end
    @(negedge clk);
  endtask

  task automatic step(input logic [5:0] ev, input logic we, input logic [1:0] a,
                      input logic [7:0] wd, input logic dn, input logic rt);
    drive(ev, we, a, wd, dn, rt);
    tick();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1D0C_2B7A));
    rst_n = 1'b0;
    b_evt = '0; b_we = 1'b0; b_addr = '0; b_wd = '0; b_done = 1'b0; b_reti = 1'b0;
    m_pend = '0; m_en = '0; m_lvl = '0; m_gen = 1'b0; m_ih = 1'b0; m_il = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every register and of the request outputs
    for (int a = 0; a < 4; a++) begin
      drive(6'h0, 1'b0, 2'(a), 8'h0, 1'b1, 1'b0);
      chk("R1 reset read", int'(rdata), 0);
      chk("R1 reset req", int'(req), 0);
      tick();
    end

    // R2: masked event still latches
    step(6'h08, 1'b0, 2'd0, 8'h0, 1'b1, 1'b0);
    drive(6'h0, 1'b0, 2'd0, 8'h0, 1'b1, 1'b0);
    chk("R2 masked flag set", int'(rdata), 8'h08);
    chk("R4 masked no req", int'(req), 0);
    tick();

    // R3: clear in the same cycle as an event wins, a later event sets again
    step(6'h02, 1'b1, 2'd0, 8'h00, 1'b0, 1'b0);
    drive(6'h0, 1'b0, 2'd0, 8'h0, 1'b0, 1'b0);
    chk("R3 clear beats event", int'(rdata), 0);
    tick();
    step(6'h02, 1'b0, 2'd0, 8'h0, 1'b0, 1'b0);
    drive(6'h0, 1'b1, 2'd0, 8'h00, 1'b0, 1'b0);
    chk("R3 later event sets", int'(rdata), 8'h02);
    tick();

    // configuration: global on, all enabled, source 4 high level
    step(6'h0, 1'b1, 2'd3, 8'h80, 1'b0, 1'b0);
    step(6'h0, 1'b1, 2'd1, 8'h3F, 1'b0, 1'b0);
    step(6'h0, 1'b1, 2'd2, 8'h10, 1'b0, 1'b0);
    step(6'h16, 1'b0, 2'd0, 8'h0, 1'b0, 1'b0);

    drive(6'h0, 1'b0, 2'd0, 8'h0, 1'b1, 1'b0);
    chk("R6 high wins take", int'(take), 1);
    chk("R6 high wins vec", int'(vec), 35);
    tick();
    drive(6'h0, 1'b0, 2'd0, 8'h0, 1'b1, 1'b0);
    chk("R8 high handler not preempted", int'(take), 0);
    tick();
    drive(6'h0, 1'b0, 2'd0, 8'h0, 1'b1, 1'b1);
    chk("R11 no take at return", int'(take), 0);
    tick();
    drive(6'h0, 1'b0, 2'd0, 8'h0, 1'b1, 1'b0);
    chk("R11 re-entry next boundary", int'(take), 1);
    chk("R11 re-entry vec", int'(vec), 35);
    tick();

    step(6'h0, 1'b1, 2'd0, 8'h06, 1'b0, 1'b0);
    step(6'h0, 1'b0, 2'd0, 8'h0, 1'b1, 1'b1);
    drive(6'h0, 1'b0, 2'd0, 8'h0, 1'b1, 1'b0);
    chk("R6 lowest low index", int'(vec), 11);
    tick();
    drive(6'h0, 1'b0, 2'd0, 8'h0, 1'b1, 1'b0);
    chk("R8 low not preempting low", int'(take), 0);
    chk("R10 flag kept without autoclear", int'(rdata), 8'h06);
    tick();

    step(6'h10, 1'b0, 2'd0, 8'h0, 1'b0, 1'b0);
    drive(6'h0, 1'b0, 2'd0, 8'h0, 1'b1, 1'b0);
    chk("R8 high preempts low", int'(take), 1);
    chk("R8 preempt vec", int'(vec), 35);
    tick();
    step(6'h0, 1'b1, 2'd0, 8'h06, 1'b0, 1'b0);
    step(6'h0, 1'b0, 2'd0, 8'h0, 1'b1, 1'b1);
    drive(6'h0, 1'b0, 2'd0, 8'h0, 1'b0, 1'b0);
    chk("R9 low still in service", int'(req), 0);
    tick();
    step(6'h0, 1'b0, 2'd0, 8'h0, 1'b1, 1'b1);
    drive(6'h0, 1'b0, 2'd0, 8'h0, 1'b1, 1'b0);
    chk("R9 both cleared take", int'(take), 1);
    tick();

    step(6'h0, 1'b1, 2'd0, 8'h00, 1'b0, 1'b0);
    step(6'h0, 1'b0, 2'd0, 8'h0, 1'b1, 1'b1);
    step(6'h05, 1'b0, 2'd0, 8'h0, 1'b0, 1'b0);
    drive(6'h0, 1'b0, 2'd0, 8'h0, 1'b1, 1'b0);
    chk("R10 take src0 vec", int'(vec), 3);
    tick();
    drive(6'h0, 1'b0, 2'd0, 8'h0, 1'b0, 1'b0);
    chk("R10 autoclear flag", int'(rdata), 8'h04);
    tick();
    step(6'h0, 1'b0, 2'd0, 8'h0, 1'b1, 1'b1);
    step(6'h0, 1'b1, 2'd3, 8'h00, 1'b0, 1'b0);
    drive(6'h0, 1'b0, 2'd0, 8'h0, 1'b1, 1'b0);
    chk("R4 global off blocks", int'(take), 0);
    tick();

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      logic [5:0] ev;
      logic       we, dn, rt;
      logic [1:0] a;
      logic [7:0] wd;
      ev = 6'($urandom) & 6'($urandom) & 6'($urandom);
      we = ($urandom % 8) == 0;
      a  = 2'($urandom);
      wd = 8'($urandom);
      if (a == 2'd3) wd[7] = ($urandom % 5) != 0;
      dn = $urandom % 2;
      rt = dn && (m_ih || m_il) && (($urandom % 4) == 0);
      step(ev, we, a, wd, dn, rt);
    end

    finish_run();
  end
endmodule